// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Sync

This block is the timing core of one PWM channel. A 16-bit counter steps on a prescaled clock tick. It counts upward and wraps to zero, counts downward and reloads the period, or climbs to the period and falls back to zero as a triangle. It marks the arrival at zero and at the period with one-cycle strobes, and it shows the current counting direction. The compare and waveform stages that follow it use these outputs to build the PWM edges.

Several channels can be chained so that their counters run in step or hold a fixed offset. A sync event comes from the `sync_in` pin or from a self-clearing command bit. When phase loading is on, a sync event puts the phase value into the counter. In triangle mode, a control bit picks which way the counter heads after that load. Each channel drives a registered `sync_out` to the next channel in the chain, and its source is selectable. The period can be written straight into the active register, or it can be written to a shadow copy that moves into the active register when the counter next counts into zero. Software reaches four registers through a one-cycle write port and a combinational read port.

The counter is a three-state machine with the states `ST_IDLE`, `ST_RISE` and `ST_FALL`. Its transitions are:

- **start**: `ST_IDLE` moves to `ST_RISE` in up or triangle mode, and to `ST_FALL` in down mode.
- **halt**: any running state moves to `ST_IDLE` when the mode is set to halt.
- **mode swap**: `ST_RISE` and `ST_FALL` switch into each other when the mode changes between up and down.
- **peak**: `ST_RISE` moves to `ST_FALL` when a triangle-mode tick arrives at or above the period.
- **floor**: `ST_FALL` moves to `ST_RISE` when a triangle-mode tick arrives at zero.
- **sync steer**: a phase load in triangle mode forces `ST_RISE` or `ST_FALL`, as the post-sync bit selects.

Top module: `pwm_timebase`

## Requirements
- R1: The mode field is CTRL[1:0]. Its encodings are 00 for up, 01 for down, 10 for triangle and 11 for halt. With period P, up mode shows 0,1,..,P,0 on successive ticks. Down mode shows P,P-1,..,0,P. Triangle mode shows 0,1,..,P,P-1,..,1,0, which repeats every 2P ticks.
- R2: `tick_zero` is high for exactly one clock when a counting step moves the counter to 0. `tick_period` is high for exactly one clock when a counting step moves the counter to the active period. Both strobes appear in the same cycle as the new count.
- R3: `dir` is 1 in up mode and 0 in down mode. In triangle mode it is 1 while the counter climbs, including the peak value, and 0 while it falls, including zero. It is 0 in halt.
- R4: A sync event (`sync_in` high at a clock edge) loads the phase register into the counter on that edge when CTRL[2] is 1. When CTRL[2] is 0, the event leaves the count untouched.
- R5: `sync_out` is registered. Its source is CTRL[5:4]: 00 gives the sync event one cycle late, 01 gives the zero strobe in the same cycle as `tick_zero`, 10 gives `cmpb_match` one cycle late, and 11 holds it low.
- R6: A CTRL write with bit 6 set raises a sync event on that write edge, with the same effect as `sync_in`. Bit 6 always reads back as 0.
- R7: When CTRL[3] is 1, period writes go to a shadow copy that becomes active when the counter next counts into zero. When CTRL[3] is 0, a period write is active from the next cycle.
- R8: In triangle mode, a phase load sets the next direction to rising if CTRL[7] is 1 and to falling if it is 0. In up and down modes, CTRL[7] has no effect on `dir` or on the count sequence.
- R9: CTRL[10:8]=k sets the counter to step once every 2^k clocks, for k from 0 to 7. A sync phase load restarts the divider.
- R10: After reset, the count is 0, CTRL reads 0x0033 (halt mode, sync output off), the period is 0, and no strobe is high. In halt mode the count holds and no strobes occur.
- R11: The register addresses are 0 for CTRL, 1 for the active period, 2 for phase and 3 for count. A write to address 3 loads the counter on the next cycle. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| sync_in | input | 1 | Sync event from the previous channel or an external pin |
| cmpb_match | input | 1 | Compare-B equality strobe from the compare stage |
| count | output | 16 | Current counter value |
| dir | output | 1 | Count direction, 1 = rising |
| tick_zero | output | 1 | Counter-reached-zero strobe |
| tick_period | output | 1 | Counter-reached-period strobe |
| sync_out | output | 1 | Sync event to the next channel |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit prescale field. The full 1 to 128 division range is therefore selectable. Small periods of 2 to 20 bring several wraps, peaks and shadow transfers into a few dozen cycles each. With these values, one run covers a phase load on both sides of the triangle, a shadow period held back until a zero crossing, and a prescaled strobe that must stay one clock wide while the count holds for four.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HALT = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        SYO_PASS = 2'b00,
        SYO_ZERO = 2'b01,
        SYO_CMPB = 2'b10,
        SYO_OFF  = 2'b11
    } sync_src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RISE = 2'b01,
        ST_FALL = 2'b10
    } cnt_state_e;

    // Control word, MSB first: prescale, post-sync dir, sw sync,
    // sync source, shadow enable, phase enable, mode
    typedef struct packed {
        logic [2:0] ps;
        logic       post_up;
        logic       sw;
        sync_src_e  sync_sel;
        logic       shadow_en;
        logic       phase_en;
        cnt_mode_e  mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRD  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PHS  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd3;

    localparam ctrl_t CTRL_RESET = '{
        ps:        3'd0,
        post_up:   1'b0,
        sw:        1'b0,
        sync_sel:  SYO_OFF,
        shadow_en: 1'b0,
        phase_en:  1'b0,
        mode:      MODE_HALT
    };

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              zero_hit,
    output ctrl_t             ctrl_q,
    output logic              sw_sync,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  prd_active,
    output logic [CNT_W-1:0]  phase_q,
    output logic [CNT_W-1:0]  rd_data
);

    localparam int PAD_W = CNT_W - CTRL_W;

    ctrl_t            wr_ctrl;
    logic             ctrl_wr;
    logic             prd_wr;
    logic             phs_wr;
    logic             prd_xfer;
    logic             sw_req;
    logic [CNT_W-1:0] prd_shadow;

    always_comb begin
        wr_ctrl    = ctrl_t'(wr_data[CTRL_W-1:0]);
        sw_req     = wr_ctrl.sw;
        wr_ctrl.sw = 1'b0;
    end

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign prd_wr   = wr_en && (wr_addr == ADDR_PRD);
    assign phs_wr   = wr_en && (wr_addr == ADDR_PHS);
    assign cnt_wr   = wr_en && (wr_addr == ADDR_CNT);
    assign sw_sync  = ctrl_wr && sw_req;
    assign prd_xfer = ctrl_q.shadow_en && zero_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            phase_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q  <= wr_ctrl;
            if (phs_wr)  phase_q <= wr_data;
        end
    end

    // The shadow always takes the write; the active copy either follows
    // at once or waits for the next counted arrival at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_shadow <= '0;
            prd_active <= '0;
        end else begin
            if (prd_wr) prd_shadow <= wr_data;
            if (prd_wr && !ctrl_q.shadow_en) begin
                prd_active <= wr_data;
            end else if (prd_xfer) begin
                prd_active <= prd_shadow;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = {{PAD_W{1'b0}}, ctrl_q};
            ADDR_PRD:  rd_data = prd_active;
            ADDR_PHS:  rd_data = phase_q;
            ADDR_CNT:  rd_data = count;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    // lim = 2^ps - 1 as a right-aligned run of ones
    assign lim  = {DIV_W{1'b1}} >> (DIV_W - int'(ps));
    assign tick = (div_q >= lim) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || (div_q >= lim)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] prd,
    input  logic             sync_load,
    input  logic [CNT_W-1:0] phase,
    input  logic             post_up,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wr_val,
    output logic [CNT_W-1:0] count,
    output logic             dir,
    output logic             zero_hit,
    output logic             zero_evt,
    output logic             prd_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             step;
    logic             prd_hit;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        step  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (mode == MODE_DOWN) begin
                    st_d = ST_FALL;
                end else if (mode != MODE_HALT) begin
                    st_d = ST_RISE;
                end
            end
            ST_RISE: begin
                if (mode == MODE_HALT) begin
                    st_d = ST_IDLE;
                end else if (mode == MODE_DOWN) begin
                    st_d = ST_FALL;
                end else if (tick) begin
                    step = 1'b1;
                    if (mode == MODE_UP) begin
                        cnt_d = (cnt_q >= prd) ? '0 : cnt_q + ONE;
                    end else if (cnt_q >= prd) begin
                        st_d  = ST_FALL;
                        cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            ST_FALL: begin
                if (mode == MODE_HALT) begin
                    st_d = ST_IDLE;
                end else if (mode == MODE_UP) begin
                    st_d = ST_RISE;
                end else if (tick) begin
                    step = 1'b1;
                    if (mode == MODE_DOWN) begin
                        cnt_d = (cnt_q == '0) ? prd : cnt_q - ONE;
                    end else if (cnt_q == '0) begin
                        st_d  = ST_RISE;
                        cnt_d = (prd == '0) ? '0 : ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase

        // Loads override counting; a sync load outranks a register write.
        if (sync_load) begin
            step  = 1'b0;
            cnt_d = phase;
            if (mode == MODE_UPDN) begin
                st_d = post_up ? ST_RISE : ST_FALL;
            end
        end else if (cnt_wr) begin
            step  = 1'b0;
            cnt_d = cnt_wr_val;
        end
    end

    assign zero_hit = step && (cnt_d == '0);
    assign prd_hit  = step && (cnt_d == prd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_evt <= 1'b0;
            prd_evt  <= 1'b0;
        end else begin
            zero_evt <= zero_hit;
            prd_evt  <= prd_hit;
        end
    end

    assign count = cnt_q;
    assign dir   = (st_q == ST_RISE);

endmodule

// File: rtl/tbase_syncout.sv
module tbase_syncout
    import pwm_tbase_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sync_src_e sel,
    input  logic      sync_evt,
    input  logic      zero_hit,
    input  logic      cmpb_match,
    output logic      sync_out
);

    logic src;

    always_comb begin
        unique case (sel)
            SYO_PASS: src = sync_evt;
            SYO_ZERO: src = zero_hit;
            SYO_CMPB: src = cmpb_match;
            SYO_OFF:  src = 1'b0;
            default:  src = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_out <= 1'b0;
        end else begin
            sync_out <= src;
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              sync_in,
    input  logic              cmpb_match,
    output logic [CNT_W-1:0]  count,
    output logic              dir,
    output logic              tick_zero,
    output logic              tick_period,
    output logic              sync_out
);

    ctrl_t            ctrl_q;
    logic             sw_sync;
    logic             cnt_wr;
    logic             sync_evt;
    logic             sync_load;
    logic             tick;
    logic             zero_hit;
    logic [CNT_W-1:0] prd_active;
    logic [CNT_W-1:0] phase_q;

    assign sync_evt  = sync_in || sw_sync;
    assign sync_load = sync_evt && ctrl_q.phase_en;

    tbase_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .count      (count),
        .zero_hit   (zero_hit),
        .ctrl_q     (ctrl_q),
        .sw_sync    (sw_sync),
        .cnt_wr     (cnt_wr),
        .prd_active (prd_active),
        .phase_q    (phase_q),
        .rd_data    (rd_data)
    );

    tbase_prescaler #(.PS_W(PS_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sync_load),
        .ps    (ctrl_q.ps[PS_W-1:0]),
        .tick  (tick)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (ctrl_q.mode),
        .tick       (tick),
        .prd        (prd_active),
        .sync_load  (sync_load),
        .phase      (phase_q),
        .post_up    (ctrl_q.post_up),
        .cnt_wr     (cnt_wr),
        .cnt_wr_val (wr_data),
        .count      (count),
        .dir        (dir),
        .zero_hit   (zero_hit),
        .zero_evt   (tick_zero),
        .prd_evt    (tick_period)
    );

    tbase_syncout u_syo (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (ctrl_q.sync_sel),
        .sync_evt   (sync_evt),
        .zero_hit   (zero_hit),
        .cmpb_match (cmpb_match),
        .sync_out   (sync_out)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [1:0]       sync_sel,
    input logic             sync_load,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] phase,
    input logic [CNT_W-1:0] prd,
    input logic [CNT_W-1:0] count,
    input logic             dir,
    input logic             tick_zero,
    input logic             tick_period,
    input logic             sync_out
);

    assert_zero_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_zero |-> (count == '0));

    assert_period_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_period |-> (count == prd));

    assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b00 && mode == 2'b00 && !$past(sync_load)
         && !$past(cnt_wr) && count != $past(count))
        |-> (count == CNT_W'($past(count) + 1'b1) || count == '0));

    assert_updn_rising_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10 && mode == 2'b10 && !$past(sync_load)
         && !$past(cnt_wr) && count > $past(count))
        |-> dir);

    assert_phase_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_load) |-> (count == $past(phase)));

    assert_sync_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_sel) == 2'b11) |-> !sync_out);

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11 && !$past(sync_load) && !$past(cnt_wr))
        |-> ($stable(count) && !tick_zero && !tick_period));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (ctrl_q.mode),
    .sync_sel    (ctrl_q.sync_sel),
    .sync_load   (sync_load),
    .cnt_wr      (cnt_wr),
    .phase       (phase_q),
    .prd         (prd_active),
    .count       (count),
    .dir         (dir),
    .tick_zero   (tick_zero),
    .tick_period (tick_period),
    .sync_out    (sync_out)
);

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sync_in = 1'b0;
    logic        cmpb_match = 1'b0;
    logic [15:0] count;
    logic        dir;
    logic        tick_zero;
    logic        tick_period;
    logic        sync_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pwm_timebase uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .sync_in     (sync_in),
        .cmpb_match  (cmpb_match),
        .count       (count),
        .dir         (dir),
        .tick_zero   (tick_zero),
        .tick_period (tick_period),
        .sync_out    (sync_out)
    );

    localparam logic [1:0] M_UP = 2'b00, M_DN = 2'b01, M_UD = 2'b10, M_HALT = 2'b11;
    localparam logic [1:0] S_PASS = 2'b00, S_ZERO = 2'b01, S_CMPB = 2'b10, S_OFF = 2'b11;

    task automatic expect_eq(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_ctrl(input logic [1:0] mode, input bit phs, input bit shd,
                                            input logic [1:0] ssel, input bit sw, input bit up,
                                            input logic [2:0] ps);
        return {5'b0, ps, up, sw, ssel, shd, phs, mode};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_zero(input string req);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (tick_zero) return;
        end
        expect_eq(req, "zero strobe seen", 0, 1);
    endtask

    task automatic wait_period(input string req);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (tick_period) return;
        end
        expect_eq(req, "period strobe seen", 0, 1);
    endtask

    task automatic park();
        wr(2'd0, mk_ctrl(M_HALT, 0, 0, S_OFF, 0, 0, 3'd0));
        wr(2'd3, 16'd0);
    endtask

    task automatic pulse_sync();
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        expect_eq("R10", "reset count", count, 0);
        expect_eq("R10", "reset dir", dir, 0);
        expect_eq("R10", "reset tick_zero", tick_zero, 0);
        expect_eq("R10", "reset tick_period", tick_period, 0);
        expect_eq("R10", "reset sync_out", sync_out, 0);
        rd(2'd0, v); expect_eq("R10", "reset ctrl", v, 16'h0033);
        rd(2'd1, v); expect_eq("R10", "reset period", v, 0);
    endtask

    task automatic t_up();
        park();
        wr(2'd1, 16'd4);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_OFF, 0, 0, 3'd0));
        wait_zero("R1");
        for (int k = 0; k < 12; k++) begin
            expect_eq("R1", "up count", count, k % 5);
            expect_eq("R2", "up zero strobe", tick_zero, (k % 5) == 0);
            expect_eq("R2", "up period strobe", tick_period, (k % 5) == 4);
            expect_eq("R3", "up dir", dir, 1);
            @(negedge clk);
        end
    endtask

    task automatic t_down();
        wr(2'd0, mk_ctrl(M_DN, 0, 0, S_OFF, 0, 0, 3'd0));
        wait_zero("R1");
        for (int k = 0; k < 12; k++) begin
            expect_eq("R1", "down count", count, (5 - (k % 5)) % 5);
            expect_eq("R2", "down zero strobe", tick_zero, (k % 5) == 0);
            expect_eq("R2", "down period strobe", tick_period, (k % 5) == 1);
            expect_eq("R3", "down dir", dir, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_updown();
        park();
        wr(2'd1, 16'd3);
        wr(2'd0, mk_ctrl(M_UD, 0, 0, S_OFF, 0, 0, 3'd0));
        wait_zero("R1");
        for (int k = 0; k < 14; k++) begin
            int m = k % 6;
            expect_eq("R1", "triangle count", count, (m <= 3) ? m : 6 - m);
            expect_eq("R3", "triangle dir", dir, (m >= 1 && m <= 3));
            expect_eq("R2", "triangle zero strobe", tick_zero, m == 0);
            expect_eq("R2", "triangle period strobe", tick_period, m == 3);
            @(negedge clk);
        end
    endtask

    task automatic t_prescale();
        park();
        wr(2'd1, 16'd2);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_OFF, 0, 0, 3'd2));
        wait_zero("R9");
        for (int k = 0; k < 24; k++) begin
            expect_eq("R9", "divided count", count, (k / 4) % 3);
            expect_eq("R9", "divided zero strobe width", tick_zero, (k % 12) == 0);
            @(negedge clk);
        end
    endtask

    task automatic t_shadow();
        logic [15:0] v;
        park();
        wr(2'd1, 16'd4);
        wr(2'd0, mk_ctrl(M_UP, 0, 1, S_OFF, 0, 0, 3'd0));
        wait_zero("R7");
        wr(2'd1, 16'd2);
        rd(2'd1, v); expect_eq("R7", "shadowed period not yet active", v, 4);
        wait_period("R7");
        expect_eq("R7", "old period still in use", count, 4);
        wait_zero("R7");
        rd(2'd1, v); expect_eq("R7", "period moved at zero", v, 2);
        wait_period("R7");
        expect_eq("R7", "new period in use", count, 2);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_OFF, 0, 0, 3'd0));
        wr(2'd1, 16'd6);
        rd(2'd1, v); expect_eq("R7", "direct period write", v, 6);
    endtask

    task automatic t_phase();
        logic [15:0] c;
        park();
        wr(2'd1, 16'd20);
        wr(2'd2, 16'd7);
        wr(2'd0, mk_ctrl(M_UP, 1, 0, S_OFF, 0, 0, 3'd0));
        repeat (3) @(negedge clk);
        pulse_sync();
        expect_eq("R4", "phase loaded on sync", count, 7);
        @(negedge clk);
        expect_eq("R4", "counting resumes after load", count, 8);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_OFF, 0, 0, 3'd0));
        @(negedge clk);
        c = count;
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        expect_eq("R4", "sync ignored when phase load off", count, (c == 20) ? 0 : c + 1);
    endtask

    task automatic t_swsync();
        logic [15:0] v;
        park();
        wr(2'd1, 16'd20);
        wr(2'd2, 16'd12);
        wr(2'd0, mk_ctrl(M_UP, 1, 0, S_OFF, 0, 0, 3'd0));
        repeat (2) @(negedge clk);
        wr(2'd0, mk_ctrl(M_UP, 1, 0, S_OFF, 1, 0, 3'd0));
        expect_eq("R6", "software sync loads phase", count, 12);
        rd(2'd0, v); expect_eq("R6", "sync command bit reads zero", v[6], 0);
    endtask

    task automatic t_postdir();
        park();
        wr(2'd1, 16'd20);
        wr(2'd2, 16'd5);
        wr(2'd0, mk_ctrl(M_UD, 1, 0, S_OFF, 0, 0, 3'd0));
        repeat (3) @(negedge clk);
        pulse_sync();
        expect_eq("R8", "triangle load falling count", count, 5);
        expect_eq("R8", "triangle load falling dir", dir, 0);
        @(negedge clk);
        expect_eq("R8", "falling after load", count, 4);
        wr(2'd0, mk_ctrl(M_UD, 1, 0, S_OFF, 0, 1, 3'd0));
        pulse_sync();
        expect_eq("R8", "triangle load rising dir", dir, 1);
        @(negedge clk);
        expect_eq("R8", "rising after load", count, 6);
        wr(2'd0, mk_ctrl(M_UP, 1, 0, S_OFF, 0, 0, 3'd0));
        @(negedge clk);
        pulse_sync();
        expect_eq("R8", "up mode ignores post-sync bit dir", dir, 1);
        @(negedge clk);
        expect_eq("R8", "up mode keeps rising", count, 6);
    endtask

    task automatic t_syncout();
        int seen = 0;
        park();
        wr(2'd1, 16'd4);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_PASS, 0, 0, 3'd0));
        pulse_sync();
        expect_eq("R5", "pass-through sync_out high", sync_out, 1);
        @(negedge clk);
        expect_eq("R5", "pass-through sync_out one cycle", sync_out, 0);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_ZERO, 0, 0, 3'd0));
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (tick_zero) seen++;
            expect_eq("R5", "zero source tracks tick_zero", sync_out, tick_zero);
        end
        expect_eq("R5", "zero source fired", seen > 0, 1);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_CMPB, 0, 0, 3'd0));
        @(negedge clk); cmpb_match = 1'b1;
        @(negedge clk); cmpb_match = 1'b0;
        expect_eq("R5", "compare-B source high", sync_out, 1);
        @(negedge clk);
        expect_eq("R5", "compare-B source low", sync_out, 0);
        wr(2'd0, mk_ctrl(M_UP, 0, 0, S_OFF, 0, 0, 3'd0));
        sync_in = 1'b1; cmpb_match = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            expect_eq("R5", "disabled sync_out", sync_out, 0);
        end
        sync_in = 1'b0; cmpb_match = 1'b0;
    endtask

    task automatic t_halt_and_write();
        logic [15:0] v;
        logic [15:0] c;
        wr(2'd0, mk_ctrl(M_HALT, 0, 0, S_OFF, 0, 0, 3'd0));
        @(negedge clk);
        c = count;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            expect_eq("R10", "halt holds count", count, c);
            expect_eq("R10", "halt no zero strobe", tick_zero, 0);
        end
        expect_eq("R3", "halt dir", dir, 0);
        wr(2'd3, 16'd9);
        expect_eq("R11", "counter write", count, 9);
        rd(2'd3, v); expect_eq("R11", "counter readback", v, 9);
        wr(2'd2, 16'd33);
        rd(2'd2, v); expect_eq("R11", "phase readback", v, 33);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up();
        t_down();
        t_updown();
        t_prescale();
        t_shadow();
        t_phase();
        t_swsync();
        t_postdir();
        t_syncout();
        t_halt_and_write();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule